// File: doc/BRIEF.md
# Asynchronous Host Bus Slave with Memory Decode

This block is the slave side of a non-multiplexed, asynchronous, strobe-based host bus. The bus has a 16-bit data path, a 15-bit address and active-low chip select and data strobe. A read/write line gives the direction. An active-low transfer acknowledge tells the host when a cycle is done. The block runs on a free-running interface clock. It resynchronises the strobes and decodes each access to one of two targets: a small internal register file, or one of four 8192-word memories.

The four memories are two connection memories (local and backplane) and two data memories (local and backplane). The host can read and write the connection memories. It can only read the data memories. The memories sit behind one shared synchronous RAM port with a read latency of one cycle. A memory access is served only once a master-clock transition has been seen. If the master switching clock has stopped, a watchdog still completes the handshake. Read data is then flagged as invalid, so the host bus never hangs.

Top module: `host_bus_slave`

## Requirements
- R1: While reset is held and just after it, the acknowledge output dta_no is high, data_oe_o is low and mem_req_o is low.
- R2: With address bit 14 low, the access targets NUM_REGS 16-bit registers indexed by the low address bits, which read back what was written. Such accesses never raise mem_req_o and need no master clock.
- R3: With address bit 14 high, the access targets memory. mem_sel_o[1] equals address bit 13 (0 local, 1 backplane). mem_sel_o[0] equals bit 0 of register 0 (0 connection memory, 1 data memory). mem_addr_o equals address bits 12:0.
- R4: A host write to a connection memory issues exactly one single-cycle mem_req_o with mem_we_o high and mem_wdata_o equal to the bus data.
- R5: A host write to a data memory raises no mem_req_o; the stored word is unchanged when read back, and the handshake still completes.
- R6: A host read from either memory type returns the word the RAM port presents one cycle after the request.
- R7: dta_no goes low only once data_o holds the read result, and data_o stays constant while dta_no is low. data_oe_o is high exactly while dta_no is low during a read.
- R8: dta_no stays low while chip select or data strobe is still asserted, and returns high only after both are released.
- R9: If no master-clock transition is seen within WDOG_CYCLES (default 8) interface cycles of a memory access starting, the block raises no mem_req_o and still drives dta_no low. During a read, rd_invalid_o is high while dta_no is low.
- R10: Chip select and data strobe pass through two-flop synchronisers. dta_no therefore stays high for at least the first two interface clock edges after both go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mclk_i | input | 1 | Master switching clock, watched for activity |
| cs_ni | input | 1 | Chip select, active low |
| ds_ni | input | 1 | Data strobe, active low |
| rw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 15 | Host address |
| data_i | input | 16 | Host write data |
| data_o | output | 16 | Host read data |
| data_oe_o | output | 1 | Read data drive enable |
| dta_no | output | 1 | Transfer acknowledge, active low |
| rd_invalid_o | output | 1 | Read data is meaningless (master clock absent) |
| mem_req_o | output | 1 | RAM port request strobe |
| mem_we_o | output | 1 | RAM port write enable |
| mem_sel_o | output | 2 | {backplane, data-memory} select |
| mem_addr_o | output | 13 | RAM word address |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data, valid one cycle after request |

## Verification
The hardest situation to reach is a memory access made while the master clock is absent. That is the only path through the timeout branch, and the one place where rd_invalid_o can rise. The bench generates the master clock from a gated process. It stops that process at a fixed level, then reads and writes a connection memory. It checks that the handshake completes, that no RAM request appears, and that the earlier contents survive. It then restarts the clock and confirms that normal service resumes.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REG,
    ST_WAIT,
    ST_ISSUE,
    ST_CAPT,
    ST_ACK
  } acc_state_e;

  localparam int unsigned MODE_BIT = 0;  // reg 0: 0 connection, 1 data memory
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/mclk_watchdog.sv
module mclk_watchdog #(
  parameter int unsigned WDOG_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  input  logic arm_i,
  output logic edge_o,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(WDOG_CYCLES + 1);

  logic         mclk_s, mclk_prev_q;
  logic [CW-1:0] cnt_q;

  sync_2ff #(.W(1), .RST_VAL(1'b0)) i_sync_mclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mclk_i),
    .q_o   (mclk_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mclk_prev_q <= 1'b0;
    else         mclk_prev_q <= mclk_s;
  end

  assign edge_o    = mclk_s ^ mclk_prev_q;
  assign expired_o = (cnt_q == CW'(WDOG_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!arm_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/host_regs.sv
module host_regs #(
  parameter int unsigned DW       = 16,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [$clog2(NUM_REGS)-1:0] idx_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [DW-1:0]               rdata_o,
  output logic                        mode_o
);
  logic [DW-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (we_i && idx_i == g[$clog2(NUM_REGS)-1:0]) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[idx_i];
  assign mode_o  = regs_q[0][host_bus_pkg::MODE_BIT];
endmodule

// File: rtl/host_bus_slave.sv
module host_bus_slave
  import host_bus_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned AW          = 15,
  parameter int unsigned NUM_REGS    = 4,
  parameter int unsigned WDOG_CYCLES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mclk_i,
  input  logic          cs_ni,
  input  logic          ds_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          dta_no,
  output logic          rd_invalid_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [1:0]    mem_sel_o,
  output logic [AW-3:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int unsigned MEM_AW = AW - 2;
  localparam int unsigned REG_AW = $clog2(NUM_REGS);

  acc_state_e    state_q;
  logic [AW-2:0] addr_q;    // bit 14 consumed by decode
  logic          rd_q, inv_q;
  logic [DW-1:0] wdata_q, rdata_q, reg_rdata;
  logic [1:0]    strb_s;
  logic          cs_act, ds_act, mode, mclk_edge, wdog_exp;

  sync_2ff #(.W(2), .RST_VAL(2'b11)) i_sync_strb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, ds_ni}),
    .q_o   (strb_s)
  );
  assign cs_act = ~strb_s[1];
  assign ds_act = ~strb_s[0];

  mclk_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) i_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mclk_i   (mclk_i),
    .arm_i    (state_q == ST_WAIT),
    .edge_o   (mclk_edge),
    .expired_o(wdog_exp)
  );

  host_regs #(.DW(DW), .NUM_REGS(NUM_REGS)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (state_q == ST_REG && !rd_q),
    .idx_i  (addr_q[REG_AW-1:0]),
    .wdata_i(wdata_q),
    .rdata_o(reg_rdata),
    .mode_o (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      inv_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cs_act && ds_act) begin
          addr_q  <= addr_i[AW-2:0];
          rd_q    <= rw_i;
          wdata_q <= data_i;
          inv_q   <= 1'b0;
          state_q <= addr_i[AW-1] ? ST_WAIT : ST_REG;
        end
        ST_REG: begin
          if (rd_q) rdata_q <= reg_rdata;
          state_q <= ST_ACK;
        end
        ST_WAIT: begin
          if (mclk_edge) begin
            // data memories take no host writes
            state_q <= (!rd_q && mode) ? ST_ACK : ST_ISSUE;
          end else if (wdog_exp) begin
            rdata_q <= '0;
            inv_q   <= rd_q;
            state_q <= ST_ACK;
          end
        end
        ST_ISSUE: state_q <= rd_q ? ST_CAPT : ST_ACK;
        ST_CAPT: begin
          rdata_q <= mem_rdata_i;
          state_q <= ST_ACK;
        end
        ST_ACK: if (!cs_act && !ds_act) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dta_no       = (state_q != ST_ACK);
  assign data_oe_o    = (state_q == ST_ACK) && rd_q;
  assign rd_invalid_o = (state_q == ST_ACK) && inv_q;
  assign data_o       = rdata_q;

  assign mem_req_o    = (state_q == ST_ISSUE);
  assign mem_we_o     = !rd_q;
  assign mem_sel_o    = {addr_q[AW-2], mode};
  assign mem_addr_o   = addr_q[MEM_AW-1:0];
  assign mem_wdata_o  = wdata_q;
endmodule

// File: rtl/host_bus_slave_chk.sv
module host_bus_slave_chk #(
  parameter int unsigned DW          = 16,
  parameter int unsigned WDOG_CYCLES = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dta_no,
  input logic          data_oe_o,
  input logic [DW-1:0] data_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [1:0]    mem_sel_o,
  input logic          rd_invalid_o,
  input logic          cs_act,
  input logic          ds_act
);
  int unsigned stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              stall_q <= 0;
    else if (!cs_act || !ds_act || !dta_no)   stall_q <= 0;
    else                                      stall_q <= stall_q + 1;
  end

  a_r5_no_dm_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_sel_o[0]);

  a_r4_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r7_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dta_no && $past(!dta_no) |-> $stable(data_o));

  a_r7_oe_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !dta_no);

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dta_no) |-> !$past(cs_act) && !$past(ds_act));

  a_r9_inv_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_invalid_o |-> !dta_no);

  a_r9_bounded_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q <= WDOG_CYCLES + 6);
endmodule

bind host_bus_slave host_bus_slave_chk #(.DW(DW), .WDOG_CYCLES(WDOG_CYCLES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dta_no      (dta_no),
  .data_oe_o   (data_oe_o),
  .data_o      (data_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_sel_o   (mem_sel_o),
  .rd_invalid_o(rd_invalid_o),
  .cs_act      (cs_act),
  .ds_act      (ds_act)
);

// File: tb/test_host_bus_slave.sv
module test_host_bus_slave;
  logic        clk_i = 1'b0, rst_ni = 1'b0, mclk_i = 1'b0, mclk_en = 1'b1;
  logic        cs_ni = 1'b1, ds_ni = 1'b1, rw_i = 1'b1;
  logic [14:0] addr_i = '0;
  logic [15:0] data_i = '0, data_o, mem_wdata_o, mem_rdata_i;
  logic        data_oe_o, dta_no, rd_invalid_o, mem_req_o, mem_we_o;
  logic [1:0]  mem_sel_o;
  logic [12:0] mem_addr_o;

  int n_run = 0, n_fail = 0, n_req = 0, n_dm_wr = 0;
  logic [15:0] mem [4][64];

  always #2.5 clk_i = ~clk_i;
  initial forever begin
    #10;
    if (mclk_en) mclk_i = ~mclk_i;
  end

  host_bus_slave i_host_bus_slave (.*);

  // RAM model: one-cycle read latency
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      n_req <= n_req + 1;
      if (mem_we_o) begin
        mem[mem_sel_o][mem_addr_o[5:0]] <= mem_wdata_o;
        if (mem_sel_o[0]) n_dm_wr <= n_dm_wr + 1;
      end
      mem_rdata_i <= mem[mem_sel_o][mem_addr_o[5:0]];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [14:0] a, input bit rd, input logic [15:0] wd,
                        output logic [15:0] rdat, output logic inv, output logic oe, output bit ok);
    int n;
    @(negedge clk_i);
    addr_i = a; rw_i = rd; data_i = wd; cs_ni = 0; ds_ni = 0;
    n = 0;
    while (dta_no && n < 100) begin @(negedge clk_i); n++; end
    ok = !dta_no;
    rdat = data_o; inv = rd_invalid_o; oe = data_oe_o;
    cs_ni = 1; ds_ni = 1;
    n = 0;
    while (!dta_no && n < 100) begin @(negedge clk_i); n++; end
    ok = ok && dta_no;
    rw_i = 1;
  endtask

  task automatic wr(input logic [14:0] a, input logic [15:0] d, input string req);
    logic [15:0] r; logic inv, oe; bit ok;
    access(a, 0, d, r, inv, oe, ok);
    check(ok, req, {31'd0, ok}, 32'd1);
  endtask

  task automatic rd_chk(input logic [14:0] a, input logic [15:0] exp, input string req);
    logic [15:0] r; logic inv, oe; bit ok;
    access(a, 1, 16'h0, r, inv, oe, ok);
    check(ok && oe && !inv && r == exp, req, {13'd0, ok, oe, inv, r}, {16'h0006, exp});
  endtask

  task automatic t_reset;
    check(dta_no && !data_oe_o && !mem_req_o, "R1", {dta_no, data_oe_o, mem_req_o}, 3'b100);
  endtask

  task automatic t_regs;
    int r0 = n_req;
    wr(15'h0001, 16'hA5A5, "R2");
    wr(15'h0002, 16'h1234, "R2");
    rd_chk(15'h0001, 16'hA5A5, "R2");
    rd_chk(15'h0002, 16'h1234, "R2");
    check(n_req == r0, "R2 no mem req", n_req, r0);
  endtask

  task automatic t_cm;
    int r0;
    wr(15'h0000, 16'h0000, "R3 mode=conn");
    r0 = n_req;
    wr(15'h4005, 16'h1111, "R4");
    wr(15'h6005, 16'h2222, "R4");
    check(n_req == r0 + 2, "R4 one req each", n_req, r0 + 2);
    check(mem[0][5] == 16'h1111 && mem[2][5] == 16'h2222, "R3 local/backplane",
          {mem[0][5], mem[2][5]}, 32'h11112222);
    rd_chk(15'h4005, 16'h1111, "R6 local cm");
    rd_chk(15'h6005, 16'h2222, "R6 backplane cm");
  endtask

  task automatic t_dm;
    mem[1][7] = 16'hBEEF; mem[3][7] = 16'hCAFE;
    wr(15'h0000, 16'h0001, "R3 mode=data");
    rd_chk(15'h4007, 16'hBEEF, "R3 local dm");
    rd_chk(15'h6007, 16'hCAFE, "R6 backplane dm");
    wr(15'h4007, 16'h0000, "R5 handshake");
    rd_chk(15'h4007, 16'hBEEF, "R5 unchanged");
    check(n_dm_wr == 0, "R5 no dm write", n_dm_wr, 0);
    wr(15'h0000, 16'h0000, "R3 mode=conn");
  endtask

  task automatic t_hold;
    int n;
    logic [15:0] d0;
    bit ok = 1;
    @(negedge clk_i);
    addr_i = 15'h4005; rw_i = 1; cs_ni = 0; ds_ni = 0;
    n = 0;
    while (dta_no && n < 100) begin @(negedge clk_i); n++; end
    d0 = data_o;
    ds_ni = 1;   // cs still held
    repeat (6) begin
      @(negedge clk_i);
      if (dta_no || !data_oe_o || data_o != d0) ok = 0;
    end
    check(ok && d0 == 16'h1111, "R8/R7 hold while cs", {15'd0, ok, d0}, {16'h0001, 16'h1111});
    cs_ni = 1;
    n = 0;
    while (!dta_no && n < 100) begin @(negedge clk_i); n++; end
    check(dta_no && !data_oe_o, "R8 release", {dta_no, data_oe_o}, 2'b10);
  endtask

  task automatic t_sync;
    bit early = 0;
    @(negedge clk_i);
    addr_i = 15'h0001; rw_i = 1; cs_ni = 0; ds_ni = 0;
    repeat (2) begin
      @(negedge clk_i);
      if (!dta_no) early = 1;
    end
    check(!early, "R10 sync delay", early, 0);
    repeat (3) @(negedge clk_i);
    check(!dta_no && data_o == 16'hA5A5, "R10 completes", {dta_no, data_o}, {1'b0, 16'hA5A5});
    cs_ni = 1; ds_ni = 1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_nomclk;
    logic [15:0] r; logic inv, oe; bit ok; int r0;
    mclk_en = 0;
    repeat (10) @(negedge clk_i);
    r0 = n_req;
    access(15'h4005, 1, 16'h0, r, inv, oe, ok);
    check(ok && inv && oe, "R9 read completes invalid", {ok, inv, oe}, 3'b111);
    access(15'h4005, 0, 16'h7777, r, inv, oe, ok);
    check(ok && !inv, "R9 write completes", {ok, inv}, 2'b10);
    check(n_req == r0 && mem[0][5] == 16'h1111, "R9 no request", {n_req[15:0], mem[0][5]},
          {r0[15:0], 16'h1111});
    rd_chk(15'h0002, 16'h1234, "R2 regs without mclk");
    mclk_en = 1;
    repeat (10) @(negedge clk_i);
    rd_chk(15'h4005, 16'h1111, "R9 recovers");
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) for (int i = 0; i < 64; i++) mem[s][i] = '0;
    mem_rdata_i = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_cm();
    t_dm();
    t_hold();
    t_sync();
    t_nomclk();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule